// File: doc/BRIEF.md
# Receive Ordering Store with Non-Posted Bypass

This block sits on the receive path between the link side and a user consumer. It accepts whole packets one beat at a time. Each packet carries a traffic class (posted, non-posted or completion), a base-address-window hit vector and a poisoned flag. It keeps each class in its own queue and hands packets on through a 64-bit framed interface. On that interface start, end, source-ready and destination-ready are all active low.

The consumer steers ordering with one active-low permission input. While non-posted traffic is permitted, packets leave in exactly the order in which they arrived, across all three classes. While it is withheld, non-posted packets stay in the store, and posted and completion packets overtake them. Those two classes still keep their own arrival order. A packet is offered only once its final beat is stored. Once a packet has started on the output, it always runs to its end beat.

Top module: `rx_order_queue`

## Requirements
- R1: A beat moves only on a clock edge where `rx_src_rdy_n` and `rx_dst_rdy_n` are both low. While the consumer holds `rx_dst_rdy_n` high, every output stays unchanged and source-ready stays low.
- R2: While `np_ok_n` is low, packets are delivered in their arrival order across all classes, and every beat is delivered intact.
- R3: While `np_ok_n` is high, no non-posted packet (`in_kind` = 1) is started. Posted (`in_kind` = 0) and completion (`in_kind` = 2) packets overtake waiting non-posted ones and keep their own mutual arrival order. With only non-posted packets stored, source-ready stays high.
- R4: A non-posted packet whose first beat has been delivered is finished, even if `np_ok_n` rises before its end beat.
- R5: `rx_rem_n` is 8'h0F on an end beat written with `in_upper_only` high, meaning only bits 63:32 hold data. It is 8'h00 on every other beat.
- R6: `rx_err_fwd_n` is low on every beat of a packet written with `in_poison` high, and high on every beat of any other packet.
- R7: `rx_bar_hit_n` is the bitwise inverse of the `in_bar` value given on the start beat. Bits 0 to 5 stand for windows 0 to 5 and bit 6 for the expansion ROM, and several bits may be set together. It stays constant from the start beat to the end beat.
- R8: `rx_src_rdy_n` is high whenever no completely written packet is pending. A packet whose end beat has not been written is never offered.
- R9: `in_full[k]` (k = the class code) is high while class k holds `MAX_PKTS` packets, or while it has fewer than `MAX_BEATS` free beat slots. It falls once a packet of that class has been delivered.
- R10: After reset `rx_src_rdy_n`, `rx_sof_n`, `rx_eof_n` and `rx_err_fwd_n` are high, `rx_bar_hit_n` is all ones and `in_full` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Write beat present |
| in_sof | input | 1 | Write beat is the first of its packet |
| in_eof | input | 1 | Write beat is the last of its packet |
| in_upper_only | input | 1 | Last beat holds data in bits 63:32 only |
| in_data | input | 64 | Write beat data |
| in_kind | input | 2 | Class on the start beat: 0 posted, 1 non-posted, 2 completion (3 is stored as completion) |
| in_bar | input | 7 | Window hit vector on the start beat, active high |
| in_poison | input | 1 | Poisoned flag on the start beat |
| in_full | output | 3 | Per-class full flags, indexed by class code |
| np_ok_n | input | 1 | Low: non-posted packets may be delivered |
| rx_data | output | 64 | Output beat data |
| rx_rem_n | output | 8 | Remainder code on the end beat |
| rx_sof_n | output | 1 | Start beat, active low |
| rx_eof_n | output | 1 | End beat, active low |
| rx_src_rdy_n | output | 1 | Beat offered, active low |
| rx_dst_rdy_n | input | 1 | Consumer accepts, active low |
| rx_err_fwd_n | output | 1 | Poisoned packet, active low |
| rx_bar_hit_n | output | 7 | Window hit vector, active low |

## Verification
A mixed batch of six packets is sent twice, with varied lengths, remainders, poison flags and hit vectors. The first time the batch is drained with non-posted traffic permitted, so any reordering or lost beat shows up. The second time it is drained with permission withheld and a stalling consumer, which separates a correct bypass from plain in-order delivery and also exposes outputs that move while stalled. Directed cases then cover the following:
- permission is dropped in the middle of a non-posted packet;
- a half-written packet is held back from the output;
- one class fills by packet count and another by beat space, which tells the two full conditions apart.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int DATA_W  = 64;
    localparam int BAR_W   = 7;
    localparam int REM_W   = 8;
    localparam int NUM_CLS = 3;

    typedef enum logic [1:0] {
        CLS_POSTED    = 2'd0,
        CLS_NONPOSTED = 2'd1,
        CLS_COMPL     = 2'd2
    } pkt_class_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              last;
        logic              upper_only;
    } beat_t;

    typedef struct packed {
        logic [BAR_W-1:0] bar;
        logic             poison;
    } pkt_attr_t;

    function automatic pkt_class_e decode_kind(input logic [1:0] kind);
        case (kind)
            2'd0:    return CLS_POSTED;
            2'd1:    return CLS_NONPOSTED;
            default: return CLS_COMPL;
        endcase
    endfunction

    function automatic logic [REM_W-1:0] rem_code(input logic last, input logic upper_only);
        return (last && upper_only) ? 8'h0F : 8'h00;
    endfunction

endpackage

// File: rtl/rxq_class_store.sv
module rxq_class_store
    import rxq_pkg::*;
#(
    parameter int DEPTH     = 12,
    parameter int MAX_PKTS  = 4,
    parameter int MAX_BEATS = 4,
    parameter int SEQ_W     = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_beat,
    input  beat_t            beat_in,
    input  logic             push_info,
    input  pkt_attr_t        attr_in,
    input  logic [SEQ_W-1:0] stamp_in,
    input  logic             mark_done,
    input  logic             pop_beat,
    input  logic             pop_pkt,
    output beat_t            head_beat,
    output pkt_attr_t        head_attr,
    output logic [SEQ_W-1:0] head_stamp,
    output logic             has_pkt,
    output logic             full
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int QW = (MAX_PKTS > 1) ? $clog2(MAX_PKTS) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int KW = $clog2(MAX_PKTS + 1);

    beat_t            beat_mem  [DEPTH];
    pkt_attr_t        attr_mem  [MAX_PKTS];
    logic [SEQ_W-1:0] stamp_mem [MAX_PKTS];

    logic [PW-1:0] bw_ptr, br_ptr;
    logic [QW-1:0] iw_ptr, ir_ptr;
    logic [CW-1:0] beat_cnt;
    logic [KW-1:0] pkt_cnt, done_cnt;

    function automatic logic [PW-1:0] bump_beat(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [QW-1:0] bump_pkt(input logic [QW-1:0] p);
        return (p == QW'(MAX_PKTS - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_beat) beat_mem[bw_ptr] <= beat_in;
        if (push_info) begin
            attr_mem[iw_ptr]  <= attr_in;
            stamp_mem[iw_ptr] <= stamp_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bw_ptr   <= '0;
            br_ptr   <= '0;
            iw_ptr   <= '0;
            ir_ptr   <= '0;
            beat_cnt <= '0;
            pkt_cnt  <= '0;
            done_cnt <= '0;
        end else begin
            if (push_beat) bw_ptr <= bump_beat(bw_ptr);
            if (pop_beat)  br_ptr <= bump_beat(br_ptr);
            if (push_info) iw_ptr <= bump_pkt(iw_ptr);
            if (pop_pkt)   ir_ptr <= bump_pkt(ir_ptr);
            beat_cnt <= beat_cnt + CW'(push_beat) - CW'(pop_beat);
            pkt_cnt  <= pkt_cnt + KW'(push_info) - KW'(pop_pkt);
            done_cnt <= done_cnt + KW'(mark_done) - KW'(pop_pkt);
        end
    end

    assign head_beat  = beat_mem[br_ptr];
    assign head_attr  = attr_mem[ir_ptr];
    assign head_stamp = stamp_mem[ir_ptr];
    assign has_pkt    = (done_cnt != '0);
    assign full       = (pkt_cnt == KW'(MAX_PKTS)) ||
                        ((CW'(DEPTH) - beat_cnt) < CW'(MAX_BEATS));

    // R9: writer never pushes into a store with no room
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        push_beat |-> (beat_cnt < CW'(DEPTH)));
    p_no_pkt_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        push_info |-> (pkt_cnt < KW'(MAX_PKTS)));
    // R8: only completely written packets are ever retired
    p_pop_complete_r8: assert property (@(posedge clk) disable iff (rst)
        pop_pkt |-> has_pkt);
    p_pop_beat_r8: assert property (@(posedge clk) disable iff (rst)
        pop_beat |-> (beat_cnt != '0));

endmodule

// File: rtl/rxq_order_pick.sv
module rxq_order_pick
    import rxq_pkg::*;
#(
    parameter int SEQ_W = 5
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_CLS-1:0]              avail,
    input  logic [NUM_CLS-1:0][SEQ_W-1:0]   stamps,
    input  logic                            np_allow,
    output logic                            any,
    output pkt_class_e                      pick
);

    logic [NUM_CLS-1:0] elig;
    logic [NUM_CLS-1:0] win;

    function automatic logic is_older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] diff;
        diff = a - b;
        return diff[SEQ_W-1];
    endfunction

    always_comb begin
        elig = avail;
        if (!np_allow) elig[CLS_NONPOSTED] = 1'b0;
    end

    for (genvar i = 0; i < NUM_CLS; i++) begin : g_cand
        logic [NUM_CLS-1:0] beats_other;
        for (genvar j = 0; j < NUM_CLS; j++) begin : g_vs
            if (i == j) begin : g_self
                assign beats_other[j] = 1'b1;
            end else begin : g_cmp
                assign beats_other[j] = !elig[j] || is_older(stamps[i], stamps[j]);
            end
        end
        assign win[i] = elig[i] && (&beats_other);
    end

    always_comb begin
        pick = CLS_POSTED;
        for (int i = 0; i < NUM_CLS; i++) begin
            if (win[i]) pick = pkt_class_e'(2'(i));
        end
    end

    assign any = |win;

    // R2: at most one class is ever judged oldest
    p_one_winner_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(win));
    // R3: withheld permission never lets a non-posted packet win
    p_np_blocked_r3: assert property (@(posedge clk) disable iff (rst)
        !np_allow |-> !win[CLS_NONPOSTED]);

endmodule

// File: rtl/rx_order_queue.sv
module rx_order_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH     = 12,
    parameter int MAX_PKTS  = 4,
    parameter int MAX_BEATS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic        in_upper_only,
    input  logic [63:0] in_data,
    input  logic [1:0]  in_kind,
    input  logic [6:0]  in_bar,
    input  logic        in_poison,
    output logic [2:0]  in_full,
    input  logic        np_ok_n,
    output logic [63:0] rx_data,
    output logic [7:0]  rx_rem_n,
    output logic        rx_sof_n,
    output logic        rx_eof_n,
    output logic        rx_src_rdy_n,
    input  logic        rx_dst_rdy_n,
    output logic        rx_err_fwd_n,
    output logic [6:0]  rx_bar_hit_n
);

    localparam int SEQ_W = $clog2(NUM_CLS * MAX_PKTS) + 1;

    // ---------------- write side ----------------
    pkt_class_e       cur_kind;
    pkt_class_e       wr_kind;
    logic [SEQ_W-1:0] seq;

    assign wr_kind = in_sof ? decode_kind(in_kind) : cur_kind;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_kind <= CLS_POSTED;
            seq      <= '0;
        end else if (in_valid && in_sof) begin
            cur_kind <= decode_kind(in_kind);
            seq      <= seq + 1'b1;
        end
    end

    // ---------------- output control ----------------
    logic       busy;
    logic       first;
    pkt_class_e sel;
    logic       xfer;

    beat_t                          head_beat  [NUM_CLS];
    pkt_attr_t                      head_attr  [NUM_CLS];
    logic [NUM_CLS-1:0][SEQ_W-1:0]  head_stamp;
    logic [NUM_CLS-1:0]             has_pkt;
    logic [NUM_CLS-1:0]             cls_full;

    beat_t     cur_beat;
    pkt_attr_t cur_attr;

    assign cur_beat = head_beat[sel];
    assign cur_attr = head_attr[sel];
    assign xfer     = busy && !rx_dst_rdy_n;

    for (genvar k = 0; k < NUM_CLS; k++) begin : g_cls
        logic  push_k;
        beat_t beat_k;
        pkt_attr_t attr_k;
        assign push_k = in_valid && (wr_kind == pkt_class_e'(2'(k)));
        assign beat_k = '{data: in_data, last: in_eof, upper_only: in_upper_only};
        assign attr_k = '{bar: in_bar, poison: in_poison};

        rxq_class_store #(
            .DEPTH     (DEPTH),
            .MAX_PKTS  (MAX_PKTS),
            .MAX_BEATS (MAX_BEATS),
            .SEQ_W     (SEQ_W)
        ) u_store (
            .clk        (clk),
            .rst        (rst),
            .push_beat  (push_k),
            .beat_in    (beat_k),
            .push_info  (push_k && in_sof),
            .attr_in    (attr_k),
            .stamp_in   (seq),
            .mark_done  (push_k && in_eof),
            .pop_beat   (xfer && (sel == pkt_class_e'(2'(k)))),
            .pop_pkt    (xfer && (sel == pkt_class_e'(2'(k))) && cur_beat.last),
            .head_beat  (head_beat[k]),
            .head_attr  (head_attr[k]),
            .head_stamp (head_stamp[k]),
            .has_pkt    (has_pkt[k]),
            .full       (cls_full[k])
        );
    end

    assign in_full = cls_full;

    logic       pick_any;
    pkt_class_e pick_cls;

    rxq_order_pick #(.SEQ_W(SEQ_W)) u_pick (
        .clk      (clk),
        .rst      (rst),
        .avail    (has_pkt),
        .stamps   (head_stamp),
        .np_allow (!np_ok_n),
        .any      (pick_any),
        .pick     (pick_cls)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            first <= 1'b0;
            sel   <= CLS_POSTED;
        end else if (!busy) begin
            if (pick_any) begin
                busy  <= 1'b1;
                first <= 1'b1;
                sel   <= pick_cls;
            end
        end else if (xfer) begin
            first <= 1'b0;
            if (cur_beat.last) busy <= 1'b0;
        end
    end

    assign rx_src_rdy_n = !busy;
    assign rx_data      = cur_beat.data;
    assign rx_sof_n     = !(busy && first);
    assign rx_eof_n     = !(busy && cur_beat.last);
    assign rx_rem_n     = busy ? rem_code(cur_beat.last, cur_beat.upper_only) : 8'h00;
    assign rx_err_fwd_n = !(busy && cur_attr.poison);
    assign rx_bar_hit_n = busy ? ~cur_attr.bar : 7'h7F;

    // R1: a stalled beat is held unchanged
    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!rx_src_rdy_n && rx_dst_rdy_n) |=>
        (!rx_src_rdy_n && $stable(rx_data) && $stable(rx_sof_n) &&
         $stable(rx_eof_n) && $stable(rx_rem_n)));
    // R7/R6: flags constant within a packet
    p_flags_const_r7: assert property (@(posedge clk) disable iff (rst)
        (!rx_src_rdy_n && !rx_dst_rdy_n && rx_eof_n) |=>
        (!rx_src_rdy_n && $stable(rx_bar_hit_n) && $stable(rx_err_fwd_n)));
    // R5: remainder only marks end beats
    p_rem_r5: assert property (@(posedge clk) disable iff (rst)
        rx_eof_n |-> (rx_rem_n == 8'h00));
    // R8: an offered packet is a complete one in its class store
    p_offer_complete_r8: assert property (@(posedge clk) disable iff (rst)
        !rx_src_rdy_n |-> has_pkt[sel]);
    // R3: a packet launched while permission is withheld is not non-posted
    p_launch_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && pick_any && np_ok_n) |=> (sel != CLS_NONPOSTED));

endmodule

// File: tb/rx_order_queue_test.sv
module rx_order_queue_test;
    import rxq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_upper_only = 1'b0;
    logic [63:0] in_data = '0;
    logic [1:0]  in_kind = '0;
    logic [6:0]  in_bar = '0;
    logic        in_poison = 1'b0;
    logic [2:0]  in_full;
    logic        np_ok_n = 1'b0;
    logic [63:0] rx_data;
    logic [7:0]  rx_rem_n;
    logic        rx_sof_n, rx_eof_n, rx_src_rdy_n;
    logic        rx_dst_rdy_n = 1'b1;
    logic        rx_err_fwd_n;
    logic [6:0]  rx_bar_hit_n;

    int errs = 0;
    int checks = 0;

    always #5 clk = ~clk;

    rx_order_queue uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_upper_only(in_upper_only), .in_data(in_data), .in_kind(in_kind),
        .in_bar(in_bar), .in_poison(in_poison), .in_full(in_full),
        .np_ok_n(np_ok_n), .rx_data(rx_data), .rx_rem_n(rx_rem_n),
        .rx_sof_n(rx_sof_n), .rx_eof_n(rx_eof_n), .rx_src_rdy_n(rx_src_rdy_n),
        .rx_dst_rdy_n(rx_dst_rdy_n), .rx_err_fwd_n(rx_err_fwd_n),
        .rx_bar_hit_n(rx_bar_hit_n)
    );

    // stimulus table: kind (0 posted, 1 non-posted, 2 completion), length,
    // upper-only end beat, poison, window hits
    localparam int NPK = 6;
    localparam int         T_KIND [NPK] = '{1, 0, 2, 1, 0, 2};
    localparam int         T_LEN  [NPK] = '{3, 1, 4, 2, 2, 1};
    localparam bit         T_HALF [NPK] = '{1, 0, 0, 1, 0, 1};
    localparam bit         T_POI  [NPK] = '{0, 1, 0, 0, 0, 1};
    localparam logic [6:0] T_BAR  [NPK] = '{7'h01, 7'h06, 7'h40, 7'h10, 7'h20, 7'h03};

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic put_beat(input int id, input int b, input int kind, input bit sof,
                            input bit eof, input bit half, input bit poi, input logic [6:0] bar);
        @(negedge clk);
        in_valid = 1'b1; in_sof = sof; in_eof = eof; in_upper_only = eof && half;
        in_data = {32'(id), 32'(b)}; in_kind = 2'(kind); in_bar = bar; in_poison = poi;
    endtask

    task automatic idle_in();
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic send_pkt(input int id, input int kind, input int len, input bit half,
                            input bit poi, input logic [6:0] bar);
        for (int b = 0; b < len; b++)
            put_beat(id, b, kind, b == 0, b == len - 1, half, poi, bar);
        idle_in();
    endtask

    task automatic drain(input int id, input int len, input bit half, input bit poi,
                         input logic [6:0] bar, input bit stall, input bit drop_np,
                         input string req);
        int b = 0;
        int cyc = 0;
        bit hold_prev = 1'b0;
        logic [63:0] snap = '0;
        while (b < len) begin
            @(negedge clk);
            cyc++;
            if (hold_prev && !rx_src_rdy_n)
                chk(rx_data == snap, "R1", "held data", rx_data, snap);
            rx_dst_rdy_n = stall ? cyc[0] : 1'b0;
            hold_prev = 1'b0;
            if (!rx_src_rdy_n) begin
                if (!rx_dst_rdy_n) begin
                    chk(rx_data == {32'(id), 32'(b)}, req, "beat data", rx_data, {32'(id), 32'(b)});
                    chk(rx_sof_n == (b != 0) && rx_eof_n == (b != len - 1), req, "framing",
                        {62'b0, rx_sof_n, rx_eof_n}, {62'b0, b != 0, b != len - 1});
                    chk(rx_rem_n == ((b == len - 1 && half) ? 8'h0F : 8'h00), "R5", "remainder",
                        64'(rx_rem_n), (b == len - 1 && half) ? 64'h0F : 64'h00);
                    chk(rx_err_fwd_n == !poi, "R6", "error forward", 64'(rx_err_fwd_n), 64'(!poi));
                    chk(rx_bar_hit_n == ~bar, "R7", "window hits", 64'(rx_bar_hit_n), 64'(~bar));
                    b++;
                    if (drop_np && b == 1) np_ok_n = 1'b1;
                end else begin
                    hold_prev = 1'b1;
                    snap = rx_data;
                end
            end
        end
        @(posedge clk);
        #1 rx_dst_rdy_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk(rx_src_rdy_n && rx_sof_n && rx_eof_n && rx_err_fwd_n, "R10", "idle controls",
            {60'b0, rx_src_rdy_n, rx_sof_n, rx_eof_n, rx_err_fwd_n}, 64'hF);
        chk(rx_bar_hit_n == 7'h7F, "R10", "idle hits", 64'(rx_bar_hit_n), 64'h7F);
        chk(in_full == 3'b000, "R10", "full flags", 64'(in_full), 64'h0);

        // Table pass 1: permission given, arrival order expected (R2)
        np_ok_n = 1'b0;
        for (int i = 0; i < NPK; i++)
            send_pkt(i, T_KIND[i], T_LEN[i], T_HALF[i], T_POI[i], T_BAR[i]);
        for (int i = 0; i < NPK; i++)
            drain(i, T_LEN[i], T_HALF[i], T_POI[i], T_BAR[i], 1'b0, 1'b0, "R2");

        // Table pass 2: permission withheld, stalling consumer (R3, R1)
        np_ok_n = 1'b1;
        for (int i = 0; i < NPK; i++)
            send_pkt(i + 10, T_KIND[i], T_LEN[i], T_HALF[i], T_POI[i], T_BAR[i]);
        for (int i = 0; i < NPK; i++)
            if (T_KIND[i] != 1)
                drain(i + 10, T_LEN[i], T_HALF[i], T_POI[i], T_BAR[i], 1'b1, 1'b0, "R3");
        repeat (10) @(negedge clk);
        chk(rx_src_rdy_n == 1'b1, "R3", "non-posted held back", 64'(rx_src_rdy_n), 64'h1);
        np_ok_n = 1'b0;
        for (int i = 0; i < NPK; i++)
            if (T_KIND[i] == 1)
                drain(i + 10, T_LEN[i], T_HALF[i], T_POI[i], T_BAR[i], 1'b0, 1'b0, "R3");

        // R4: permission dropped after first non-posted beat
        np_ok_n = 1'b0;
        send_pkt(20, 1, 4, 1'b0, 1'b1, 7'h02);
        send_pkt(21, 0, 1, 1'b1, 1'b0, 7'h08);
        drain(20, 4, 1'b0, 1'b1, 7'h02, 1'b0, 1'b1, "R4");
        drain(21, 1, 1'b1, 1'b0, 7'h08, 1'b0, 1'b0, "R4");
        repeat (4) @(negedge clk);
        chk(rx_src_rdy_n == 1'b1, "R4", "store empty after", 64'(rx_src_rdy_n), 64'h1);

        // R9: packet-count limit on non-posted, beat-space limit on posted
        np_ok_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            send_pkt(30 + i, 1, 1, 1'b0, 1'b0, 7'h01);
            if (i == 2) chk(in_full[1] == 1'b0, "R9", "np not yet full", 64'(in_full), 64'h0);
        end
        chk(in_full[1] == 1'b1, "R9", "np full by count", 64'(in_full), 64'h2);
        chk(in_full[0] == 1'b0, "R9", "posted free", 64'(in_full), 64'h2);
        for (int i = 0; i < 3; i++) begin
            send_pkt(40 + i, 0, 4, 1'b0, 1'b0, 7'h04);
            if (i == 1) chk(in_full[0] == 1'b0, "R9", "posted 8 beats", 64'(in_full), 64'h2);
        end
        chk(in_full[0] == 1'b1, "R9", "posted full by space", 64'(in_full), 64'h3);
        drain(40, 4, 1'b0, 1'b0, 7'h04, 1'b0, 1'b0, "R9");
        @(negedge clk);
        chk(in_full[0] == 1'b0, "R9", "posted freed", 64'(in_full), 64'h2);
        drain(41, 4, 1'b0, 1'b0, 7'h04, 1'b0, 1'b0, "R9");
        drain(42, 4, 1'b0, 1'b0, 7'h04, 1'b0, 1'b0, "R9");
        np_ok_n = 1'b0;
        drain(30, 1, 1'b0, 1'b0, 7'h01, 1'b0, 1'b0, "R9");
        @(negedge clk);
        chk(in_full[1] == 1'b0, "R9", "np freed", 64'(in_full), 64'h0);
        for (int i = 1; i < 4; i++)
            drain(30 + i, 1, 1'b0, 1'b0, 7'h01, 1'b0, 1'b0, "R2");

        // R8: a half-written packet is not offered
        put_beat(50, 0, 0, 1'b1, 1'b0, 1'b0, 1'b0, 7'h20);
        idle_in();
        repeat (8) @(negedge clk);
        chk(rx_src_rdy_n == 1'b1, "R8", "partial packet held", 64'(rx_src_rdy_n), 64'h1);
        put_beat(50, 1, 0, 1'b0, 1'b1, 1'b1, 1'b0, 7'h20);
        idle_in();
        drain(50, 2, 1'b1, 1'b0, 7'h20, 1'b0, 1'b0, "R8");
        repeat (4) @(negedge clk);
        chk(rx_src_rdy_n == 1'b1, "R8", "nothing pending", 64'(rx_src_rdy_n), 64'h1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule